// File: doc/BRIEF.md
# Character Display Host Bus Front End

This block sits between a host processor's parallel bus and the core of a character display controller. The host drives an enable strobe, a register-select line, a read/write line and an 8-bit data bus. The block turns each completed write into one instruction or data byte and passes it to the controller core over a valid/ready stream. On host reads it returns either the status word (busy flag plus the core's address counter) or the core's read-data byte.

The bus can run with a full byte per strobe or with a byte split across two strobes on the upper four data lines. Width and three display configuration bits are held in a local configuration register, loaded by a function-set instruction that the block decodes itself. After reset the bus is byte-wide. A host wired for nibble transfers leaves the lower four lines floating, and they read as ones. Its first function-set therefore arrives as a byte with the low bits high. It selects nibble mode and forces line-mode, multiplex and extended-set bits to 1, so a second function-set sent as two nibbles must follow.

Stream rules: `cmd_valid` rises only when the block is not busy. Byte and kind stay stable until `cmd_ready` is seen high with `cmd_valid`, and `cmd_valid` drops on the next cycle. There is no queue. A held byte makes the block busy, and a write that completes while busy is dropped.

Top module: `hbi_host_bus`

## Requirements
- R1: After reset the bus is byte-wide (`cfg_dl`=1), `cfg_two_line`, `cfg_mux9`, `cfg_ext` are 0, `busy` is 0 and `cmd_valid` is 0.
- R2: In byte-wide mode each falling edge of `bus_e` with `bus_rw`=0 completes a byte `bus_d_in[7:0]`, offered on the stream with `cmd_is_data` equal to `bus_rs` (1 = data, 0 = instruction).
- R3: In nibble mode a byte takes two strobes on `bus_d_in[7:4]`, high nibble first; nothing is offered after the first strobe.
- R4: An instruction byte whose bits 7..5 are 001 is a function-set: bit 4 loads `cfg_dl`, bit 2 `cfg_two_line`, bit 1 `cfg_mux9`, bit 0 `cfg_ext`. It is also forwarded on the stream. With the low lines held at 1, a function-set written as 0x20 in byte-wide mode selects nibble mode and sets the other three bits to 1.
- R5: `busy` is 1 whenever a byte is held on the stream or `core_busy` is 1.
- R6: A write completed while `busy` is 1 is dropped: no byte is offered and the configuration is unchanged.
- R7: While `cmd_valid`=1 and `cmd_ready`=0 the byte and kind hold. After a handshake `cmd_valid` is 0 the next cycle.
- R8: While `bus_e`=1 with `bus_rw`=1 the block drives `bus_d_oe`=1. With `bus_rs`=0 it returns {`busy`, `core_ac`}; with `bus_rs`=1 it returns `core_rd_data`. At other times `bus_d_oe`=0.
- R9: In nibble mode a read takes two strobes, high nibble first on `bus_d_out[7:4]`, with `bus_d_out[3:0]` at 0.
- R10: The nibble phase returns to "high first" at reset and whenever `cfg_dl` changes, so the strobe after a width change starts a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_e | input | 1 | Host enable strobe (asynchronous) |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_d_in | input | 8 | Data bus from host (low lines pulled high when unused) |
| bus_d_out | output | 8 | Data bus to host |
| bus_d_oe | output | 1 | Data bus output enable |
| core_busy | input | 1 | Core internal operation in progress |
| core_ac | input | 7 | Core address counter for status reads |
| core_rd_data | input | 8 | Core read-data byte |
| cmd_valid | output | 1 | Stream byte valid |
| cmd_ready | input | 1 | Stream byte accepted by core |
| cmd_is_data | output | 1 | Stream byte kind: 1 data, 0 instruction |
| cmd_byte | output | 8 | Stream byte |
| busy | output | 1 | Busy flag |
| cfg_dl | output | 1 | 1 byte-wide bus, 0 nibble bus |
| cfg_two_line | output | 1 | 0 one line of 32, 1 two lines of 16 |
| cfg_mux9 | output | 1 | 1:9 multiplex, one line of 16 |
| cfg_ext | output | 1 | Extended instruction set selected |

## Verification
The bench sweeps every combination of the three display bits through function-set, then drives the floating-low-line power-up case. A design that ignored the pulled-up lines would leave the display bits at 0 after the first function-set, and one that misdecoded the opcode would change configuration on ordinary instructions. Nibble writes and reads are checked over several byte values. A swapped nibble order or a byte offered after the first strobe shows up as a wrong stream byte. Writes during a held stream byte and during `core_busy` are checked to be dropped, which catches a design that overwrites the held byte or updates configuration while busy. The switch back to byte-wide mode is followed at once by a full byte, which catches a nibble phase that is left stale.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef struct packed {
    logic dl;
    logic m;
    logic sl;
    logic h;
  } hbi_cfg_t;

  localparam logic [2:0] HBI_FSET_OP = 3'b001;

  localparam hbi_cfg_t HBI_CFG_RST = '{dl: 1'b1, m: 1'b0, sl: 1'b0, h: 1'b0};

  function automatic logic hbi_is_fset(input logic [7:0] b);
    return b[7:5] == HBI_FSET_OP;
  endfunction

  function automatic hbi_cfg_t hbi_fset_fields(input logic [7:0] b);
    hbi_cfg_t c;
    c.dl = b[4];
    c.m  = b[2];
    c.sl = b[1];
    c.h  = b[0];
    return c;
  endfunction
endpackage

// File: rtl/hbi_strobe_sync.sv
module hbi_strobe_sync #(
  parameter int STAGES = 2,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_in,
  input  logic          rs_in,
  input  logic          rw_in,
  input  logic [DW-1:0] d_in,
  output logic          e_hi,
  output logic          e_fall,
  output logic          rs_s,
  output logic          rw_s,
  output logic [DW-1:0] d_s
);
  localparam int VW = DW + 3;

  logic [STAGES-1:0][VW-1:0] chain;
  logic                      e_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain[0] <= '0;
    end else begin
      chain[0] <= {e_in, rs_in, rw_in, d_in};
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_prev <= 1'b0;
    else        e_prev <= e_hi;
  end

  assign e_hi   = chain[STAGES-1][VW-1];
  assign rs_s   = chain[STAGES-1][VW-2];
  assign rw_s   = chain[STAGES-1][VW-3];
  assign d_s    = chain[STAGES-1][DW-1:0];
  assign e_fall = e_prev & ~e_hi;
endmodule

// File: rtl/hbi_nibble_asm.sv
module hbi_nibble_asm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_fall,
  input  logic          rs_s,
  input  logic          rw_s,
  input  logic [DW-1:0] d_s,
  input  logic          dl,
  output logic          hi_phase,
  output logic          byte_done,
  output logic          byte_rs,
  output logic [DW-1:0] byte_val
);
  localparam int NW = DW / 2;

  logic          dl_q;
  logic [NW-1:0] hi_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q      <= 1'b1;
      hi_phase  <= 1'b1;
      hi_hold   <= '0;
      byte_done <= 1'b0;
      byte_rs   <= 1'b0;
      byte_val  <= '0;
    end else begin
      dl_q      <= dl;
      byte_done <= 1'b0;
      if (dl != dl_q) begin
        hi_phase <= 1'b1;
      end else if (e_fall) begin
        if (dl) begin
          hi_phase <= 1'b1;
          if (!rw_s) begin
            byte_done <= 1'b1;
            byte_rs   <= rs_s;
            byte_val  <= d_s;
          end
        end else if (hi_phase) begin
          hi_phase <= 1'b0;
          if (!rw_s) hi_hold <= d_s[DW-1:NW];
        end else begin
          hi_phase <= 1'b1;
          if (!rw_s) begin
            byte_done <= 1'b1;
            byte_rs   <= rs_s;
            byte_val  <= {hi_hold, d_s[DW-1:NW]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/hbi_cfg_reg.sv
module hbi_cfg_reg
  import hbi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic          byte_rs,
  input  logic [DW-1:0] byte_val,
  input  logic          busy,
  output logic          accept,
  output hbi_cfg_t      cfg
);
  assign accept = byte_done & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= HBI_CFG_RST;
    end else if (accept && !byte_rs && hbi_is_fset(byte_val)) begin
      cfg <= hbi_fset_fields(byte_val);
    end
  end
endmodule

// File: rtl/hbi_out_stage.sv
module hbi_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_rs,
  input  logic [DW-1:0] load_val,
  input  logic          ready,
  output logic          valid,
  output logic          is_data,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      is_data <= 1'b0;
      data    <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      is_data <= load_rs;
      data    <= load_val;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hbi_host_bus.sv
module hbi_host_bus
  import hbi_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AC_W        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_e,
  input  logic            bus_rs,
  input  logic            bus_rw,
  input  logic [DW-1:0]   bus_d_in,
  output logic [DW-1:0]   bus_d_out,
  output logic            bus_d_oe,
  input  logic            core_busy,
  input  logic [AC_W-1:0] core_ac,
  input  logic [DW-1:0]   core_rd_data,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic            cmd_is_data,
  output logic [DW-1:0]   cmd_byte,
  output logic            busy,
  output logic            cfg_dl,
  output logic            cfg_two_line,
  output logic            cfg_mux9,
  output logic            cfg_ext
);
  localparam int NW = DW / 2;

  logic          e_hi, e_fall, rs_s, rw_s;
  logic [DW-1:0] d_s;
  logic          hi_phase, byte_done, byte_rs, accept;
  logic [DW-1:0] byte_val, rd_word;
  hbi_cfg_t      cfg;

  hbi_strobe_sync #(.STAGES(SYNC_STAGES), .DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .e_in(bus_e), .rs_in(bus_rs), .rw_in(bus_rw),
    .d_in(bus_d_in), .e_hi(e_hi), .e_fall(e_fall), .rs_s(rs_s), .rw_s(rw_s),
    .d_s(d_s)
  );

  hbi_nibble_asm #(.DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_n), .e_fall(e_fall), .rs_s(rs_s), .rw_s(rw_s),
    .d_s(d_s), .dl(cfg.dl), .hi_phase(hi_phase), .byte_done(byte_done),
    .byte_rs(byte_rs), .byte_val(byte_val)
  );

  hbi_cfg_reg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_rs(byte_rs),
    .byte_val(byte_val), .busy(busy), .accept(accept), .cfg(cfg)
  );

  hbi_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_rs(byte_rs),
    .load_val(byte_val), .ready(cmd_ready), .valid(cmd_valid),
    .is_data(cmd_is_data), .data(cmd_byte)
  );

  assign busy = cmd_valid | core_busy;

  always_comb begin
    rd_word = '0;
    if (rs_s) rd_word = core_rd_data;
    else      rd_word = {busy, core_ac};
  end

  assign bus_d_oe = e_hi & rw_s;

  always_comb begin
    bus_d_out = '0;
    if (bus_d_oe) begin
      if (cfg.dl)        bus_d_out = rd_word;
      else if (hi_phase) bus_d_out = {rd_word[DW-1:NW], {NW{1'b0}}};
      else               bus_d_out = {rd_word[NW-1:0], {NW{1'b0}}};
    end
  end

  assign cfg_dl       = cfg.dl;
  assign cfg_two_line = cfg.m;
  assign cfg_mux9     = cfg.sl;
  assign cfg_ext      = cfg.h;
endmodule

// File: rtl/hbi_host_bus_chk.sv
module hbi_host_bus_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_is_data,
  input logic [DW-1:0] cmd_byte,
  input logic          busy,
  input logic          core_busy,
  input logic          bus_d_oe,
  input logic [DW-1:0] bus_d_out,
  input logic          cfg_dl,
  input logic          cfg_two_line,
  input logic          cfg_mux9,
  input logic          cfg_ext
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_is_data));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || core_busy) |-> busy);

  p_no_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !$past(busy));

  p_cfg_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_dl, cfg_two_line, cfg_mux9, cfg_ext}) |->
      cmd_valid && !cmd_is_data && cmd_byte[7:5] == 3'b001);

  p_nib_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_d_oe && !cfg_dl |-> bus_d_out[3:0] == 4'h0);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_d_oe |-> bus_d_out == '0);
endmodule

bind hbi_host_bus hbi_host_bus_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_is_data(cmd_is_data), .cmd_byte(cmd_byte), .busy(busy),
  .core_busy(core_busy), .bus_d_oe(bus_d_oe), .bus_d_out(bus_d_out),
  .cfg_dl(cfg_dl), .cfg_two_line(cfg_two_line), .cfg_mux9(cfg_mux9),
  .cfg_ext(cfg_ext)
);

// File: tb/test_hbi_host_bus.sv
`timescale 1ns/1ps
module test_hbi_host_bus;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_d_in = 8'hFF;
  logic [7:0] bus_d_out;
  logic       bus_d_oe;
  logic       core_busy = 1'b0;
  logic [6:0] core_ac = 7'h00;
  logic [7:0] core_rd_data = 8'h00;
  logic       cmd_valid, cmd_is_data, busy;
  logic       cmd_ready = 1'b0;
  logic [7:0] cmd_byte;
  logic       cfg_dl, cfg_two_line, cfg_mux9, cfg_ext;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  hbi_host_bus i_hbi_host_bus (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .core_busy(core_busy), .core_ac(core_ac), .core_rd_data(core_rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_data(cmd_is_data),
    .cmd_byte(cmd_byte), .busy(busy), .cfg_dl(cfg_dl),
    .cfg_two_line(cfg_two_line), .cfg_mux9(cfg_mux9), .cfg_ext(cfg_ext)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe_wr(input logic rs, input logic [7:0] d);
    bus_rs = rs; bus_rw = 1'b0; bus_d_in = d;
    wait_cyc(2);
    bus_e = 1'b1;
    wait_cyc(4);
    bus_e = 1'b0;
    wait_cyc(6);
  endtask

  task automatic nib_wr(input logic rs, input logic [7:0] b);
    strobe_wr(rs, {b[7:4], 4'hF});
    strobe_wr(rs, {b[3:0], 4'hF});
  endtask

  task automatic strobe_rd(input logic rs, output logic [7:0] q, output logic oe);
    bus_rs = rs; bus_rw = 1'b1;
    wait_cyc(2);
    bus_e = 1'b1;
    wait_cyc(4);
    q = bus_d_out; oe = bus_d_oe;
    bus_e = 1'b0;
    wait_cyc(6);
    bus_rw = 1'b0;
  endtask

  task automatic drain();
    cmd_ready = 1'b1;
    wait_cyc(1);
    cmd_ready = 1'b0;
    wait_cyc(1);
    chk(!cmd_valid, "R7 valid drops after handshake", cmd_valid, 0);
  endtask

  task automatic chk_cfg(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {cfg_dl, cfg_two_line, cfg_mux9, cfg_ext};
    chk(act == exp, req, act, exp);
  endtask

  initial begin
    for (;;) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] q, q2, b;
    logic oe;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk_cfg("R1 reset cfg", 4'b1000);
    chk(!busy, "R1 busy clear", busy, 0);
    chk(!cmd_valid, "R1 no stream", cmd_valid, 0);

    // R2 byte-wide instruction write, ready held low
    strobe_wr(1'b0, 8'h01);
    chk(cmd_valid && cmd_byte == 8'h01 && !cmd_is_data, "R2 instr byte", cmd_byte, 8'h01);
    chk(busy, "R5 busy while held", busy, 1);
    core_ac = 7'h2A;
    strobe_rd(1'b0, q, oe);
    chk(oe && q == 8'hAA, "R8 status read busy+ac", q, 8'hAA);
    // R6 write while held is dropped
    strobe_wr(1'b0, 8'h02);
    chk(cmd_byte == 8'h01, "R6 held byte kept", cmd_byte, 8'h01);
    drain();
    chk(!busy, "R5 busy clears", busy, 0);

    // R2 data write
    strobe_wr(1'b1, 8'h5C);
    chk(cmd_valid && cmd_byte == 8'h5C && cmd_is_data, "R2 data byte", cmd_byte, 8'h5C);
    drain();

    // R4 sweep of display bits with byte-wide function-set
    for (int k = 0; k < 8; k++) begin
      b = 8'h30 | 8'(k);
      strobe_wr(1'b0, b);
      chk(cmd_valid && cmd_byte == b, "R4 fset forwarded", cmd_byte, b);
      chk_cfg("R4 fset fields", {1'b1, 3'(k)});
      drain();
    end
    // R4 non-fset instruction leaves cfg
    strobe_wr(1'b0, 8'h47);
    chk_cfg("R4 non-fset ignored", 4'b1111);
    drain();
    strobe_wr(1'b0, 8'h30);
    drain();

    // R4 power-up with floating low lines
    strobe_wr(1'b0, 8'h2F);
    chk(cmd_byte == 8'h2F, "R4 pulled-up fset byte", cmd_byte, 8'h2F);
    chk_cfg("R4 pulled-up fset forces bits", 4'b0111);
    drain();

    // R3 second fset as two nibbles
    strobe_wr(1'b0, 8'h2F);
    chk(!cmd_valid, "R3 nothing after high nibble", cmd_valid, 0);
    strobe_wr(1'b0, 8'h0F);
    chk(cmd_valid && cmd_byte == 8'h20, "R3 assembled fset", cmd_byte, 8'h20);
    chk_cfg("R4 nibble fset clears bits", 4'b0000);
    drain();

    // R3 nibble data sweep
    for (int k = 0; k < 8; k++) begin
      b = 8'((k * 37 + 11) & 8'hFF);
      nib_wr(1'b1, b);
      chk(cmd_valid && cmd_is_data && cmd_byte == b, "R3 nibble data byte", cmd_byte, b);
      drain();
    end

    // R9 nibble status read
    core_ac = 7'h35;
    strobe_rd(1'b0, q, oe);
    strobe_rd(1'b0, q2, oe);
    chk(q == 8'h30, "R9 high nibble first", q, 8'h30);
    chk(q2 == 8'h50, "R9 low nibble second", q2, 8'h50);

    // R6 core busy drops write, cfg unchanged
    core_busy = 1'b1;
    nib_wr(1'b0, 8'h30);
    chk(!cmd_valid, "R6 dropped while core busy", cmd_valid, 0);
    chk_cfg("R6 cfg unchanged", 4'b0000);
    core_busy = 1'b0;

    // R10 switch back to byte-wide; next strobe is a whole byte
    nib_wr(1'b0, 8'h30);
    chk_cfg("R10 byte-wide again", 4'b1000);
    drain();
    strobe_wr(1'b1, 8'hA5);
    chk(cmd_valid && cmd_byte == 8'hA5, "R10 full byte after width change", cmd_byte, 8'hA5);
    drain();

    // R8 data read in byte-wide mode
    core_rd_data = 8'hC3;
    strobe_rd(1'b1, q, oe);
    chk(oe && q == 8'hC3, "R8 data read", q, 8'hC3);
    chk(!bus_d_oe, "R8 oe low after strobe", bus_d_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule